// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets synchronous logic reach an external 512K x 8 asynchronous static RAM one byte at a time. A host raises a request with a direction bit, a 19-bit byte address and, for writes, a data byte. The controller accepts the request only in the cycle that its ready output is high. It then produces the active-low chip-select, output-enable and write-strobe signals for the memory. The byte bus is split into an outgoing data byte with its own driver enable and an incoming data byte, so a pad ring can build the bidirectional pin.

Every phase length is a whole number of clock cycles. Each one is the ceiling of a nanosecond minimum divided by the clock-period parameter, and never less than one cycle. A read keeps select and output enable low for the full read window and samples the byte on the last edge of that window. A write keeps select and the write strobe low long enough to cover the strobe width, the select-to-end time and the data setup time. A recovery phase then stretches the write to the full cycle time. After every read, a quiet gap lets the memory release the bus before the controller may drive it.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, `ready` is 1 and `rd_valid` is 0.
- R2: An accepted read (`req_we` = 0) holds `mem_ce_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for exactly RD = max(1, ceil(120 / CLK_PERIOD_NS)) cycles, starting in the cycle after acceptance. `mem_addr` stays steady throughout.
- R3: `mem_din` is sampled on the clock edge that ends the read window. `rd_data` shows that byte, and `rd_valid` is 1 for exactly one cycle: the first cycle after the window.
- R4: An accepted write (`req_we` = 1) holds `mem_ce_n` and `mem_we_n` at 0 for exactly WP = max(1, ceil(100 / CLK_PERIOD_NS)) cycles. During that time `mem_oe_n` is 1, `mem_dout_en` is 1, and `mem_addr` and `mem_dout` are steady. The byte is stored at the requested address.
- R5: After the write strobe rises, `mem_ce_n` stays 0 and the driver stays on for WR = max(1, ceil(120 / CLK_PERIOD_NS) - WP) cycles. Both then release. `ready` is 0 for WP + WR cycles after acceptance.
- R6: `mem_dout_en` is never 1 while `mem_oe_n` is 0.
- R7: After a read window, all strobes stay inactive with the driver off for TA = max(1, ceil(35 / CLK_PERIOD_NS)) cycles before `ready` returns. `ready` is therefore 0 for RD + TA cycles after a read is accepted.
- R8: `ready` is 1 only when the controller is idle, with all three strobes at 1 and the driver off. A request with `ready` at 1 is accepted on that edge.
- R9: The address, data and direction of a request are latched on acceptance. Changes on `req`, `req_we`, `req_addr` and `req_wdata` after that have no effect on the operation in progress.
- R10: When the clock period exceeds every minimum, each phase lasts exactly one cycle. A read or a write then keeps `ready` low for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled when ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Idle, request may be presented |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle pulse marking new rd_data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 19 | Memory address |
| mem_dout | output | 8 | Byte driven toward the memory |
| mem_dout_en | output | 1 | Driver enable for mem_dout |
| mem_din | input | 8 | Byte received from the memory |

## Verification
The hardest condition to show from the ports is that the read byte is taken exactly at the end of the full access window, no earlier. The bench's memory model returns a garbage byte until the select and output enable have been low for the whole window, so sampling one cycle early yields a wrong `rd_data`. The second hard case is a write that directly follows a read. The vector table places writes right after reads so that the turnaround gap is measured through the `ready` low time and the driver enable.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WREC
    } sramc_state_e;

    typedef struct packed {
        sramc_state_e state;
        logic         ce_n;
        logic         oe_n;
        logic         we_n;
        logic         drv;
    } sramc_ctrl_t;

    // Ceiling of ns / period, never below one cycle.
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_cycle_timer.sv
`timescale 1ns/1ps
module sramc_cycle_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sramc_req_hold.sv
`timescale 1ns/1ps
module sramc_req_hold #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        if (load) begin
            addr_d = addr_in;
            data_d = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign addr_out = addr_q;
    assign data_out = data_q;

endmodule

// File: rtl/sramc_rd_capture.sv
`timescale 1ns/1ps
module sramc_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] data_d, data_q;
    logic              vld_d, vld_q;

    always_comb begin
        data_d = cap ? din : data_q;
        vld_d  = cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rd_data  = data_q;
    assign rd_valid = vld_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 120,  // read cycle / access time
    parameter int T_WC_NS       = 120,  // write cycle time
    parameter int T_WP_NS       = 80,   // write strobe width
    parameter int T_CW_NS       = 100,  // select and address to write end
    parameter int T_DW_NS       = 50,   // data setup to write end
    parameter int T_HZ_NS       = 35    // memory bus release time
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    import sramc_pkg::*;

    localparam int RD_CYC   = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int WP_CYC   = ns_to_cycles(imax(imax(T_WP_NS, T_CW_NS), T_DW_NS), CLK_PERIOD_NS);
    localparam int WC_CYC   = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int WREC_CYC = imax(1, WC_CYC - WP_CYC);
    localparam int TURN_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(WREC_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam sramc_ctrl_t IDLE_CTRL = '{state: ST_IDLE, ce_n: 1'b1, oe_n: 1'b1,
                                          we_n: 1'b1, drv: 1'b0};

    sramc_ctrl_t      ctrl_d, ctrl_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             accept;
    logic             cap;

    always_comb begin
        ctrl_d = ctrl_q;
        t_load = 1'b0;
        t_val  = '0;
        accept = 1'b0;
        cap    = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    t_load = 1'b1;
                    if (req_we) begin
                        ctrl_d = '{state: ST_WRITE, ce_n: 1'b0, oe_n: 1'b1,
                                   we_n: 1'b0, drv: 1'b1};
                        t_val  = CNT_W'(WP_CYC - 1);
                    end else begin
                        ctrl_d = '{state: ST_READ, ce_n: 1'b0, oe_n: 1'b0,
                                   we_n: 1'b1, drv: 1'b0};
                        t_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (t_done) begin
                    cap    = 1'b1;
                    t_load = 1'b1;
                    t_val  = CNT_W'(TURN_CYC - 1);
                    ctrl_d = '{state: ST_TURN, ce_n: 1'b1, oe_n: 1'b1,
                               we_n: 1'b1, drv: 1'b0};
                end
            end
            ST_TURN: begin
                if (t_done) ctrl_d = IDLE_CTRL;
            end
            ST_WRITE: begin
                if (t_done) begin
                    t_load = 1'b1;
                    t_val  = CNT_W'(WREC_CYC - 1);
                    ctrl_d = '{state: ST_WREC, ce_n: 1'b0, oe_n: 1'b1,
                               we_n: 1'b1, drv: 1'b1};
                end
            end
            ST_WREC: begin
                if (t_done) ctrl_d = IDLE_CTRL;
            end
            default: ctrl_d = IDLE_CTRL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= IDLE_CTRL;
        else        ctrl_q <= ctrl_d;
    end

    sramc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sramc_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .data_in  (req_wdata),
        .addr_out (mem_addr),
        .data_out (mem_dout)
    );

    sramc_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .din      (mem_din),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign ready       = (ctrl_q.state == ST_IDLE);
    assign mem_ce_n    = ctrl_q.ce_n;
    assign mem_oe_n    = ctrl_q.oe_n;
    assign mem_we_n    = ctrl_q.we_n;
    assign mem_dout_en = ctrl_q.drv;

endmodule

// File: rtl/sramc_chk.sv
`timescale 1ns/1ps
module sramc_chk #(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WP_NS       = 80,
    parameter int T_CW_NS       = 100,
    parameter int T_DW_NS       = 50,
    parameter int T_HZ_NS       = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              rd_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);

    import sramc_pkg::*;

    localparam int WP_CYC   = ns_to_cycles(imax(imax(T_WP_NS, T_CW_NS), T_DW_NS), CLK_PERIOD_NS);
    localparam int TURN_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);

    int we_low_cnt;
    int hz_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= 0;
            hz_cnt     <= TURN_CYC;
        end else begin
            we_low_cnt <= mem_we_n ? 0 : we_low_cnt + 1;
            if (!mem_oe_n)             hz_cnt <= 0;
            else if (hz_cnt < TURN_CYC) hz_cnt <= hz_cnt + 1;
        end
    end

    // R6
    no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_oe_n));

    // R7
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (hz_cnt >= TURN_CYC));

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= WP_CYC));

    // R4
    wr_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dout_en));

    // R4
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    // R2
    rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    // R2
    rd_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    // R3
    rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R3
    rd_valid_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_oe_n && $past(!mem_oe_n)));

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

endmodule

bind sram_async_ctrl sramc_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_WP_NS       (T_WP_NS),
    .T_CW_NS       (T_CW_NS),
    .T_DW_NS       (T_DW_NS),
    .T_HZ_NS       (T_HZ_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ready       (ready),
    .rd_valid    (rd_valid),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

    // Expected phase lengths at 5 ns, worked out by hand.
    localparam int EXP_RD   = 24;  // 120 / 5
    localparam int EXP_WP   = 20;  // 100 / 5
    localparam int EXP_WREC = 4;   // 24 - 20
    localparam int EXP_TURN = 7;   // 35 / 5

    typedef struct packed {
        logic        we;
        logic [18:0] addr;
        logic [7:0]  data;
    } op_vec_t;

    localparam int NVEC = 10;
    localparam op_vec_t VEC [NVEC] = '{
        '{1'b1, 19'h00000, 8'hA5},
        '{1'b1, 19'h7FFFF, 8'h3C},
        '{1'b0, 19'h00000, 8'hA5},
        '{1'b1, 19'h12345, 8'hFF},
        '{1'b0, 19'h7FFFF, 8'h3C},
        '{1'b0, 19'h12345, 8'hFF},
        '{1'b1, 19'h55555, 8'h81},
        '{1'b0, 19'h55555, 8'h81},
        '{1'b1, 19'h00000, 8'h00},
        '{1'b0, 19'h00000, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [7:0]  rd_data, mem_dout;
    logic [7:0]  mem_din;
    logic [18:0] mem_addr;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.CLK_PERIOD_NS(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    // Slow-period instance: every phase collapses to one cycle.
    logic        s_req = 1'b0, s_req_we = 1'b0;
    logic        s_ready, s_rd_valid, s_ce_n, s_oe_n, s_we_n, s_dout_en;
    logic [7:0]  s_rd_data, s_dout;
    logic [18:0] s_addr;

    sram_async_ctrl #(.CLK_PERIOD_NS(200)) u_dut_slow (
        .clk(clk), .rst_n(rst_n), .req(s_req), .req_we(s_req_we),
        .req_addr(19'h00042), .req_wdata(8'h11), .ready(s_ready),
        .rd_data(s_rd_data), .rd_valid(s_rd_valid), .mem_ce_n(s_ce_n),
        .mem_oe_n(s_oe_n), .mem_we_n(s_we_n), .mem_addr(s_addr),
        .mem_dout(s_dout), .mem_dout_en(s_dout_en), .mem_din(8'h5A)
    );

    // Memory model: data only valid after a full access window.
    logic [7:0] mem_model [logic [18:0]];
    int rd_age = 0;

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_oe_n) rd_age <= rd_age + 1;
        else                        rd_age <= 0;
    end

    always @* begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= EXP_RD - 1)
            mem_din = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;
        else
            mem_din = 8'hEE;
    end

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0 && mem_dout_en === 1'b1)
            mem_model[mem_addr] = mem_dout;
    end

    // Monitors sampled at the falling edge.
    int we_run = 0, we_last = 0, oe_run = 0, oe_last = 0;
    int rv_cnt = 0, contention = 0;
    logic [7:0] rv_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin we_last = we_run; we_run = 0; end
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin oe_last = oe_run; oe_run = 0; end
            if (rd_valid) begin rv_cnt++; rv_data = rd_data; end
            if (mem_dout_en && !mem_oe_n) contention++;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic check_eq(input string rq, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input op_vec_t v);
        int busy;
        int rv0;
        while (!ready) @(negedge clk);
        rv0 = rv_cnt;
        req = 1'b1; req_we = v.we; req_addr = v.addr; req_wdata = v.data;
        @(negedge clk);
        // R9: scramble host inputs right after acceptance
        req = 1'b0; req_we = ~v.we; req_addr = ~v.addr; req_wdata = ~v.data;
        check_eq("R9", "latched address", int'(mem_addr), int'(v.addr));
        busy = 0;
        while (!ready) begin busy++; @(negedge clk); end
        if (v.we) begin
            check_eq("R5", "write busy cycles", busy, EXP_WP + EXP_WREC);
            check_eq("R4", "write strobe cycles", we_last, EXP_WP);
            check_eq("R4", "stored byte",
                     mem_model.exists(v.addr) ? int'(mem_model[v.addr]) : -1, int'(v.data));
        end else begin
            check_eq("R7", "read busy cycles", busy, EXP_RD + EXP_TURN);
            check_eq("R2", "read window cycles", oe_last, EXP_RD);
            check_eq("R3", "rd_valid pulses", rv_cnt - rv0, 1);
            check_eq("R3", "read byte", int'(rv_data), int'(v.data));
        end
        check_eq("R8", "idle strobes", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}), 4'b1110);
        check_eq("R6", "contention samples", contention, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        int busy;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check_eq("R1", "strobes in reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 3'b111);
        check_eq("R1", "driver in reset", int'(mem_dout_en), 0);
        check_eq("R1", "ready in reset", int'(ready), 1);
        check_eq("R1", "rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "idle after reset", int'({ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}), 5'b11110);

        for (int i = 0; i < NVEC; i++) run_op(VEC[i]);

        // R10: slow instance, one-cycle phases
        s_req = 1'b1; s_req_we = 1'b1;
        @(negedge clk);
        s_req = 1'b0;
        check_eq("R10", "slow write strobe", int'({s_ce_n, s_we_n, s_dout_en}), 3'b001);
        busy = 0;
        while (!s_ready) begin busy++; @(negedge clk); end
        check_eq("R10", "slow write busy", busy, 2);
        s_req = 1'b1; s_req_we = 1'b0;
        @(negedge clk);
        s_req = 1'b0;
        check_eq("R10", "slow read strobe", int'({s_ce_n, s_oe_n, s_we_n}), 3'b001);
        busy = 0;
        while (!s_ready) begin
            if (s_rd_valid) check_eq("R10", "slow read byte", int'(s_rd_data), 8'h5A);
            busy++; @(negedge clk);
        end
        check_eq("R10", "slow read busy", busy, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule